// File: doc/BRIEF.md
# Phase-Accumulator PWM Channel Bank with Shadowed Settings

This block drives up to four pulse-width-modulated outputs. Each channel has one 32-bit control word holding an enable bit, an update-request bit, a frequency increment (the base unit) and an 8-bit inverted duty field. An N-bit phase accumulator adds the base unit on every clock, so the output frequency is base_unit × f_clk / 2^N. The top eight accumulator bits are compared against a threshold derived from the duty field to form the high time.

Software writes new fields into a written copy of the register. They reach the running waveform only after the update bit is set, and only at the next cycle start. The hardware then clears the update bit. A write that arrives while an update is still pending cannot disturb the channel: its fields are dropped. A build-time bypass option lets a pending update complete while the channel is disabled, so that enable can be set after the new settings are already active.

Top module: `pwm_accum_top`

## Requirements
- R1: After reset every control word reads 0x00000000 and every output is low.
- R2: The control word has enable at bit 31, update-pending at bit 30, the base unit at bits 8 upward (BU_WIDTH bits wide, 16 or 22) and the duty field at bits 7:0. A read returns the written fields, and bits between the base unit and bit 30 read zero.
- R3: Writing the fields with the update bit clear leaves the waveform unchanged.
- R4: Writing with bit 30 set makes bit 30 read 1. The hardware clears it at the next cycle start, which is either an accumulator wrap or the first running clock after enable is taken.
- R5: The written base unit and duty field become active at that cycle start and stay active until the next completed update.
- R6: A write made while an update is pending drops its fields and its update bit. Its enable bit is still taken, and the pending values are the ones loaded.
- R7: The output is high while the top 8 accumulator bits are below 255 − duty field. A duty field of 255 gives a constantly low output. With base unit 256 and N = 16, every 256 consecutive clocks hold exactly 255 − duty field high clocks.
- R8: On the clock after enable is taken the accumulator is zero. On each following clock it advances by the base unit modulo 2^N.
- R9: Clearing enable drives the output low from the clock on which the register changes and returns the accumulator to zero.
- R10: A base unit of zero holds the accumulator still while enabled.
- R11: Channel c sits at byte address c × 0x400. Writes to any other offset are ignored, and reads there return 0. Addresses of channels at or above NUM_CH read 0.
- R12: With BYPASS = 1, an update requested while disabled loads on the next clock and clears bit 30. With BYPASS = 0 it stays pending until the channel is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_out | output | NUM_CH | One PWM output per channel |

## Verification
The hardest state to reach is a second configuration write that lands while an update is still pending. In running mode the pending window lasts at most one output period, which is too short and too variable to hit reliably. The bench widens it by requesting the update on a disabled channel in the non-bypass build, where the request waits indefinitely. It then issues a conflicting write and finally enables the channel. The measured high-time count must match the first settings and not the second. The duty and frequency sweeps all start from a known accumulator phase, because enabling always resets the accumulator to zero. This lets the expected high-clock counts be computed exactly from the base unit and the duty field.

// File: rtl/pwm_accum_pkg.sv
package pwm_accum_pkg;

    // Byte stride between channel register spaces is 2**STRIDE_LG.
    localparam int STRIDE_LG = 10;
    localparam int CH_MAX    = 4;
    localparam int DUTY_W    = 8;
    localparam int BU_MAX_W  = 22;

    // Control word layout; 1 + 1 + 22 + 8 = 32 bits.
    typedef struct packed {
        logic                en;
        logic                upd;
        logic [BU_MAX_W-1:0] bu;
        logic [DUTY_W-1:0]   duty;
    } ctrl_word_t;

    // Reason a pending update is loaded this clock.
    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_START = 2'd1,
        EV_WRAP  = 2'd2,
        EV_IDLE  = 2'd3
    } load_ev_t;

    // Duty field is stored inverted: high while top byte < 255 - field.
    function automatic logic [DUTY_W-1:0] high_limit(input logic [DUTY_W-1:0] duty);
        return 8'hFF - duty;
    endfunction

endpackage

// File: rtl/pwm_addr_dec.sv
module pwm_addr_dec
    import pwm_accum_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output logic [NUM_CH-1:0] sel,
    output logic [NUM_CH-1:0] wr_sel
);
    localparam int IDX_W = ADDR_W - STRIDE_LG;

    logic              off_zero;
    logic [IDX_W-1:0]  idx;

    assign off_zero = (addr[STRIDE_LG-1:0] == '0);
    assign idx      = addr[ADDR_W-1:STRIDE_LG];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
        assign sel[c]    = off_zero && (idx == IDX_W'(c));
        assign wr_sel[c] = sel[c] && wr;
    end

    // R11
    always_comb begin
        one_sel_chk: assert ($onehot0(sel));
    end

endmodule

// File: rtl/pwm_phase_gen.sv
module pwm_phase_gen
    import pwm_accum_pkg::*;
#(
    parameter int BU_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic [BU_W-1:0]     bu,
    input  logic [DUTY_W-1:0]   duty,
    output logic                start,
    output logic                wrap,
    output logic                out
);
    logic [BU_W-1:0] acc;
    logic [BU_W:0]   sum;
    logic            run;
    logic [7:0]      top;

    assign sum   = {1'b0, acc} + {1'b0, bu};
    assign start = en && !run;
    assign wrap  = en && run && sum[BU_W];
    assign top   = acc[BU_W-1 -: 8];
    assign out   = en && run && (top < high_limit(duty));

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            run <= 1'b0;
        end else begin
            run <= en;
            if (!en || !run) begin
                acc <= '0;
            end else begin
                acc <= sum[BU_W-1:0];
            end
        end
    end

    // R10
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (en && run && bu == '0) |=> (acc == $past(acc)));

    // R7
    zero_duty_chk: assert property (@(posedge clk) disable iff (rst)
        (duty == 8'hFF) |-> !out);

    // R8
    first_phase_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (acc == '0));

endmodule

// File: rtl/pwm_chan_ctrl.sv
module pwm_chan_ctrl
    import pwm_accum_pkg::*;
#(
    parameter int BU_W   = 16,
    parameter bit BYPASS = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [31:0]         wdata,
    input  logic                start,
    input  logic                wrap,
    output logic [31:0]         rdata,
    output logic                en,
    output logic [BU_W-1:0]     bu_act,
    output logic [DUTY_W-1:0]   duty_act
);
    ctrl_word_t          w;
    ctrl_word_t          r;
    logic                pend_q;
    logic [BU_W-1:0]     bu_wr;
    logic [DUTY_W-1:0]   duty_wr;
    load_ev_t            ev;
    logic                idle_load;

    assign w = ctrl_word_t'(wdata);

    if (BU_W < BU_MAX_W) begin : g_pad
        logic unused_bu_hi;
        assign unused_bu_hi = ^w.bu[BU_MAX_W-1:BU_W];
    end

    assign idle_load = BYPASS && !en;

    always_comb begin
        if (!pend_q)        ev = EV_NONE;
        else if (start)     ev = EV_START;
        else if (wrap)      ev = EV_WRAP;
        else if (idle_load) ev = EV_IDLE;
        else                ev = EV_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en       <= 1'b0;
            pend_q   <= 1'b0;
            bu_wr    <= '0;
            duty_wr  <= '0;
            bu_act   <= '0;
            duty_act <= '0;
        end else begin
            if (wr) begin
                en <= w.en;
                if (!pend_q) begin
                    bu_wr   <= w.bu[BU_W-1:0];
                    duty_wr <= w.duty;
                end
            end
            if (ev != EV_NONE) begin
                bu_act   <= bu_wr;
                duty_act <= duty_wr;
                pend_q   <= 1'b0;
            end else if (wr && !pend_q && w.upd) begin
                pend_q <= 1'b1;
            end
        end
    end

    always_comb begin
        r.en   = en;
        r.upd  = pend_q;
        r.bu   = BU_MAX_W'(bu_wr);
        r.duty = duty_wr;
    end
    assign rdata = r;

    // R4
    pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pend_q) |-> $past(start || wrap || idle_load));

    // R5
    act_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(start || wrap || idle_load) |=> ($stable(bu_act) && $stable(duty_act)));

    // R6
    busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && pend_q) |=> ($stable(bu_wr) && $stable(duty_wr)));

    // R12
    bypass_load_chk: assert property (@(posedge clk) disable iff (rst)
        (idle_load && pend_q) |=> !pend_q);

endmodule

// File: rtl/pwm_accum_top.sv
module pwm_accum_top
    import pwm_accum_pkg::*;
#(
    parameter int NUM_CH   = 2,
    parameter int BU_WIDTH = 16,
    parameter bit BYPASS   = 1'b0,
    parameter int ADDR_W   = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    logic [NUM_CH-1:0] sel;
    logic [NUM_CH-1:0] wr_sel;
    logic [NUM_CH-1:0] ch_en;
    logic [NUM_CH-1:0] ch_start;
    logic [NUM_CH-1:0] ch_wrap;
    logic [31:0]       ch_word  [NUM_CH];
    logic [BU_WIDTH-1:0] ch_bu  [NUM_CH];
    logic [DUTY_W-1:0] ch_duty  [NUM_CH];

    pwm_addr_dec #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_dec (
        .addr   (bus_addr),
        .wr     (bus_wr),
        .sel    (sel),
        .wr_sel (wr_sel)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pwm_chan_ctrl #(
            .BU_W   (BU_WIDTH),
            .BYPASS (BYPASS)
        ) u_ctrl (
            .clk      (clk),
            .rst      (rst),
            .wr       (wr_sel[c]),
            .wdata    (bus_wdata),
            .start    (ch_start[c]),
            .wrap     (ch_wrap[c]),
            .rdata    (ch_word[c]),
            .en       (ch_en[c]),
            .bu_act   (ch_bu[c]),
            .duty_act (ch_duty[c])
        );

        pwm_phase_gen #(
            .BU_W (BU_WIDTH)
        ) u_phase (
            .clk   (clk),
            .rst   (rst),
            .en    (ch_en[c]),
            .bu    (ch_bu[c]),
            .duty  (ch_duty[c]),
            .start (ch_start[c]),
            .wrap  (ch_wrap[c]),
            .out   (pwm_out[c])
        );

        // R9
        off_low_chk: assert property (@(posedge clk) disable iff (rst)
            !ch_en[c] |-> !pwm_out[c]);
    end

    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (sel[c]) bus_rdata = bus_rdata | ch_word[c];
        end
    end

endmodule

// File: tb/sim_pwm_accum_top.sv
module sim_pwm_accum_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] addr = '0;
    logic        wr0 = 1'b0;
    logic        wr1 = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata0, rdata1;
    logic [1:0]  pwm0;
    logic [0:0]  pwm1;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_accum_top #(.NUM_CH(2), .BU_WIDTH(16), .BYPASS(1'b0), .ADDR_W(12)) u0 (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr0),
        .bus_wdata(wdata), .bus_rdata(rdata0), .pwm_out(pwm0));

    pwm_accum_top #(.NUM_CH(1), .BU_WIDTH(16), .BYPASS(1'b1), .ADDR_W(12)) u1 (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr1),
        .bus_wdata(wdata), .bus_rdata(rdata1), .pwm_out(pwm1));

    function automatic logic [31:0] mk(input bit en, input bit upd,
                                       input int bu, input int duty);
        return {en, upd, 22'(bu), 8'(duty)};
    endfunction

    function automatic int exp_high(input int bu, input int duty, input int n);
        int cnt = 0;
        for (int k = 0; k < n; k++) begin
            int a = (k * bu) % 65536;
            if ((a >> 8) < (255 - duty)) cnt++;
        end
        return cnt;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input int dut, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr0 = (dut == 0); wr1 = (dut == 1);
        @(negedge clk);
        wr0 = 1'b0; wr1 = 1'b0;
    endtask

    task automatic bus_read(input int dut, input logic [11:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = (dut == 0) ? rdata0 : rdata1;
    endtask

    task automatic measure(input int dut, input int ch, input int n, output int cnt);
        cnt = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (dut == 0) cnt += int'(pwm0[ch]);
            else cnt += int'(pwm1[0]);
        end
    endtask

    // Channel assumed disabled with nothing pending; starts from phase zero.
    task automatic start_run(input logic [11:0] a, input int bu, input int duty);
        bus_write(0, a, mk(1'b0, 1'b1, bu, duty));
        bus_write(0, a, mk(1'b1, 1'b0, bu, duty));
    endtask

    task automatic wait_clear(input int dut, input logic [11:0] a);
        logic [31:0] d;
        for (int k = 0; k < 800; k++) begin
            bus_read(dut, a, d);
            if (!d[30]) break;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int cnt;
        int bus_list [7] = '{1, 128, 256, 700, 4096, 40000, 65535};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1
        bus_read(0, 12'h000, d); chk("R1 ch0 word", d, 32'h0);
        bus_read(0, 12'h400, d); chk("R1 ch1 word", d, 32'h0);
        bus_read(1, 12'h000, d); chk("R1 bypass word", d, 32'h0);
        chk("R1 outputs", {29'd0, pwm1, pwm0}, 32'h0);

        // R2: bits 29:24 written but must read zero for a 16-bit base unit
        bus_write(0, 12'h000, 32'h3F123456);
        bus_read(0, 12'h000, d); chk("R2 readback", d, 32'h00123456);

        // R11: stride, bad offsets, absent channels
        bus_write(0, 12'h400, 32'h0000AB01);
        bus_read(0, 12'h400, d); chk("R11 ch1 at 0x400", d, 32'h0000AB01);
        bus_read(0, 12'h000, d); chk("R11 ch0 untouched", d, 32'h00123456);
        bus_write(0, 12'h004, 32'hFFFFFFFF);
        bus_read(0, 12'h004, d); chk("R11 bad offset reads 0", d, 32'h0);
        bus_read(0, 12'h000, d); chk("R11 bad offset write ignored", d, 32'h00123456);
        bus_read(0, 12'h800, d); chk("R11 absent channel", d, 32'h0);
        bus_read(1, 12'h400, d); chk("R11 bypass absent ch1", d, 32'h0);
        chk("R11 no output from bad write", {30'd0, pwm0}, 32'h0);

        // R8 / R9: frequency sweep from phase zero
        for (int i = 0; i < 7; i++) begin
            for (int j = 0; j < 2; j++) begin
                int duty = (j == 0) ? 127 : 50;
                start_run(12'h000, bus_list[i], duty);
                measure(0, 0, 1024, cnt);
                chk($sformatf("R8 bu=%0d duty=%0d high count", bus_list[i], duty),
                    cnt, exp_high(bus_list[i], duty, 1024));
                bus_write(0, 12'h000, mk(1'b0, 1'b0, bus_list[i], duty));
                chk("R9 low right after disable", {31'd0, pwm0[0]}, 32'h0);
                measure(0, 0, 20, cnt);
                chk("R9 low while disabled", cnt, 0);
            end
        end

        // R7 / R4 / R5: duty sweep at base unit 256
        start_run(12'h000, 256, 0);
        for (int duty = 0; duty <= 255; duty += 15) begin
            bus_write(0, 12'h000, mk(1'b1, 1'b1, 256, duty));
            bus_read(0, 12'h000, d);
            chk("R4 pending after request", {31'd0, d[30]}, 32'h1);
            wait_clear(0, 12'h000);
            bus_read(0, 12'h000, d);
            chk("R4 pending cleared at cycle start", {31'd0, d[30]}, 32'h0);
            measure(0, 0, 256, cnt);
            chk($sformatf("R7 duty field %0d", duty), cnt, 255 - duty);
        end
        measure(0, 0, 300, cnt);
        chk("R7 field 255 stays low", cnt, 0);

        // R3: field write without update bit
        bus_write(0, 12'h000, mk(1'b1, 1'b1, 256, 100));
        wait_clear(0, 12'h000);
        bus_write(0, 12'h000, mk(1'b1, 1'b0, 256, 0));
        bus_read(0, 12'h000, d);
        chk("R3 written fields visible", d, mk(1'b1, 1'b0, 256, 0));
        measure(0, 0, 512, cnt);
        chk("R3 waveform unchanged", cnt, 2 * 155);
        bus_read(0, 12'h000, d);
        chk("R5 no pending without request", {31'd0, d[30]}, 32'h0);

        // R6 / R12: conflicting write during a held request
        bus_write(0, 12'h000, mk(1'b0, 1'b0, 256, 0));
        bus_write(0, 12'h000, mk(1'b0, 1'b1, 512, 200));
        bus_write(0, 12'h000, mk(1'b0, 1'b1, 1024, 10));
        bus_read(0, 12'h000, d);
        chk("R6 busy write dropped", d, 32'h400200C8);
        repeat (50) @(negedge clk);
        bus_read(0, 12'h000, d);
        chk("R12 no bypass stays pending", {31'd0, d[30]}, 32'h1);
        bus_write(0, 12'h000, mk(1'b1, 1'b0, 7, 7));
        measure(0, 0, 1024, cnt);
        chk("R6 first settings loaded", cnt, exp_high(512, 200, 1024));
        bus_read(0, 12'h000, d);
        chk("R6 enable taken fields kept", d, 32'h800200C8);

        // R10: base unit zero
        bus_write(0, 12'h000, mk(1'b0, 1'b0, 0, 0));
        start_run(12'h000, 0, 0);
        measure(0, 0, 300, cnt);
        chk("R10 frozen accumulator keeps output high", cnt, 300);
        bus_write(0, 12'h000, mk(1'b0, 1'b0, 0, 0));

        // R11: second channel independent
        bus_write(0, 12'h400, mk(1'b0, 1'b0, 0, 0));
        start_run(12'h400, 256, 55);
        measure(0, 1, 256, cnt);
        chk("R11 ch1 duty", cnt, 200);
        measure(0, 0, 100, cnt);
        chk("R11 ch0 idle while ch1 runs", cnt, 0);

        // R12: bypass build loads while disabled
        bus_write(1, 12'h000, mk(1'b0, 1'b1, 300, 90));
        bus_read(1, 12'h000, d);
        chk("R12 bypass pending set", {31'd0, d[30]}, 32'h1);
        @(negedge clk);
        bus_read(1, 12'h000, d);
        chk("R12 bypass cleared while disabled", d, 32'h00012C5A);
        bus_write(1, 12'h000, mk(1'b1, 1'b0, 300, 90));
        measure(1, 0, 1024, cnt);
        chk("R12 bypass settings active at enable", cnt, exp_high(300, 90, 1024));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule